// File: doc/BRIEF.md
# Range-Clamped Signed Lookup Table

The block converts a 64-bit two's-complement integer into a 27-bit result by reading a constant table that spans inputs from -100 through +100. Any input beyond that window saturates: inputs above +100 return the top table entry, and inputs below -100 return the bottom entry. The table holds 201 words in consecutive locations. The address of an in-range input is the input plus 100.

The block never compares all 64 bits against the window limits. Reduction operators over the upper bits decide whether the input lies outside a small signed band. A 9-bit compare on the sign bit and the low byte then settles the remaining cases. Each accepted input, marked by a valid strobe, produces its result one clock later together with an output valid strobe. The table contents are fixed when the design is elaborated.

Top module: `clamp_lut`

## Requirements
- R1: While rst_ni is low, valid_o is 0 and data_o is 0.
- R2: valid_o is high in exactly the cycle after each cycle in which valid_i is high at a rising clock edge. Each result appears one clock after its input is accepted, and results come out in input order.
- R3: For an input x in -100..+100, data_o is T(x+100). T(0)=495050, T(200)=99504950, and T(i)=500000*i for i in 1..199. In particular, -99 gives 500000 and 99 gives 99500000.
- R4: Any input greater than +100 gives data_o = 99504950.
- R5: Any input less than -100 gives data_o = 495050.
- R6: An input with bit 63 at 0 and any of bits 62..8 at 1 clamps high. An input with bit 63 at 1 and any of bits 62..8 at 0 clamps low. This holds up to the extreme values of the 64-bit range.
- R7: When bits 62..8 all equal bit 63, the input lies in -256..255. Within that band, 101..255 clamp high and -256..-101 clamp low.
- R8: In a cycle in which valid_i is low, data_o keeps its value and valid_o is 0, whatever value_i holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | value_i is presented for lookup |
| value_i | input | 64 | Signed input value |
| valid_o | output | 1 | data_o carries a new result |
| data_o | output | 27 | Looked-up or clamped result |

## Verification
Every result is due exactly one rising edge after its input is accepted. The bench drives inputs on the falling edge and pushes the expected word into a queue. A monitor samples on the next falling edge, whenever valid_o is high, and pops the oldest entry to compare it. Back-to-back streams therefore check both the one-cycle latency and the ordering. Idle stretches with valid_i low and a disturbing value_i check that the output holds its value during the cycles that follow.

// File: rtl/clamp_lut_pkg.sv
package clamp_lut_pkg;

  typedef enum logic [1:0] {
    CLS_INSIDE = 2'd0,
    CLS_ABOVE  = 2'd1,
    CLS_BELOW  = 2'd2
  } range_cls_e;

  // Table word for location idx of a depth-entry table.
  function automatic longint entry_val(input longint idx, input longint depth,
                                       input longint edge_lo, input longint edge_hi,
                                       input longint step);
    if (idx == 0)              return edge_lo;
    else if (idx == depth - 1) return edge_hi;
    else                       return idx * step;
  endfunction

endpackage

// File: rtl/range_classifier.sv
module range_classifier
  import clamp_lut_pkg::*;
#(
  parameter int IN_W     = 64,
  parameter int NARROW_W = 8,
  parameter int SPAN     = 100
) (
  input  logic [IN_W-1:0]            value_i,
  output range_cls_e                 cls_o,
  output logic signed [NARROW_W:0]   narrow_o
);

  localparam logic signed [NARROW_W:0] SPAN_P = (NARROW_W+1)'(SPAN);
  localparam logic signed [NARROW_W:0] SPAN_N = (NARROW_W+1)'(-SPAN);

  logic                   sign_b;
  logic [IN_W-2:NARROW_W] upper_b;
  logic                   wide_above, wide_below;
  logic                   band_above, band_below;
  logic signed [NARROW_W:0] narrow;

  assign sign_b  = value_i[IN_W-1];
  assign upper_b = value_i[IN_W-2:NARROW_W];

  // Outside the narrow band: upper bits disagree with the sign.
  assign wide_above = ~sign_b & (|upper_b);
  assign wide_below =  sign_b & ~(&upper_b);

  // Inside the band the value equals {sign, low bits} as a signed number.
  assign narrow     = {sign_b, value_i[NARROW_W-1:0]};
  assign band_above = narrow > SPAN_P;
  assign band_below = narrow < SPAN_N;

  always_comb begin
    if (wide_above || band_above)      cls_o = CLS_ABOVE;
    else if (wide_below || band_below) cls_o = CLS_BELOW;
    else                               cls_o = CLS_INSIDE;
  end

  assign narrow_o = narrow;

endmodule

// File: rtl/addr_gen.sv
module addr_gen
  import clamp_lut_pkg::*;
#(
  parameter int NARROW_W = 8,
  parameter int SPAN     = 100,
  parameter int DEPTH    = 2*SPAN + 1,
  parameter int ADDR_W   = $clog2(DEPTH)
) (
  input  range_cls_e               cls_i,
  input  logic signed [NARROW_W:0] narrow_i,
  output logic [ADDR_W-1:0]        addr_o
);

  localparam logic signed [NARROW_W+1:0] OFFSET = (NARROW_W+2)'(SPAN);
  localparam logic [ADDR_W-1:0]          TOP    = ADDR_W'(DEPTH - 1);

  logic signed [NARROW_W+1:0] shifted;

  assign shifted = (NARROW_W+2)'(narrow_i) + OFFSET;

  always_comb begin
    unique case (cls_i)
      CLS_ABOVE: addr_o = TOP;
      CLS_BELOW: addr_o = '0;
      default:   addr_o = ADDR_W'(shifted);
    endcase
  end

endmodule

// File: rtl/table_rom.sv
module table_rom
  import clamp_lut_pkg::*;
#(
  parameter int DEPTH   = 201,
  parameter int ADDR_W  = $clog2(DEPTH),
  parameter int OUT_W   = 27,
  parameter int EDGE_LO = 495050,
  parameter int EDGE_HI = 99504950,
  parameter int STEP    = 500000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [OUT_W-1:0]  data_o
);

  logic [OUT_W-1:0] words [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    assign words[g] = OUT_W'(entry_val(longint'(g), longint'(DEPTH), longint'(EDGE_LO),
                                       longint'(EDGE_HI), longint'(STEP)));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   data_o <= '0;
    else if (en_i) data_o <= words[addr_i];
  end

  a_r8_hold_when_idle : assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(data_o));

  a_r7_addr_in_table : assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |-> (int'(addr_i) < DEPTH));

endmodule

// File: rtl/clamp_lut.sv
module clamp_lut
  import clamp_lut_pkg::*;
#(
  parameter int IN_W     = 64,
  parameter int NARROW_W = 8,
  parameter int SPAN     = 100,
  parameter int OUT_W    = 27,
  parameter int EDGE_LO  = 495050,
  parameter int EDGE_HI  = 99504950,
  parameter int STEP     = 500000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [IN_W-1:0]  value_i,
  output logic             valid_o,
  output logic [OUT_W-1:0] data_o
);

  localparam int DEPTH  = 2*SPAN + 1;
  localparam int ADDR_W = $clog2(DEPTH);

  range_cls_e               cls;
  logic signed [NARROW_W:0] narrow;
  logic [ADDR_W-1:0]        addr;

  range_classifier #(
    .IN_W(IN_W), .NARROW_W(NARROW_W), .SPAN(SPAN)
  ) u_cls (
    .value_i (value_i),
    .cls_o   (cls),
    .narrow_o(narrow)
  );

  addr_gen #(
    .NARROW_W(NARROW_W), .SPAN(SPAN), .DEPTH(DEPTH), .ADDR_W(ADDR_W)
  ) u_addr (
    .cls_i   (cls),
    .narrow_i(narrow),
    .addr_o  (addr)
  );

  table_rom #(
    .DEPTH(DEPTH), .ADDR_W(ADDR_W), .OUT_W(OUT_W),
    .EDGE_LO(EDGE_LO), .EDGE_HI(EDGE_HI), .STEP(STEP)
  ) u_rom (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (valid_i),
    .addr_i(addr),
    .data_o(data_o)
  );

  // Valid pipeline matches the one-cycle table read.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_o <= 1'b0;
    else         valid_o <= valid_i;
  end

  a_r2_valid_follows : assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  a_r2_no_spurious_valid : assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);

  a_r4_clamp_high : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && cls == CLS_ABOVE) |=> (data_o == OUT_W'(EDGE_HI)));

  a_r5_clamp_low : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && cls == CLS_BELOW) |=> (data_o == OUT_W'(EDGE_LO)));

  a_r6_sign_wide_low : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && value_i[IN_W-1] && !(&value_i[IN_W-2:NARROW_W]))
      |=> (data_o == OUT_W'(EDGE_LO)));

endmodule

// File: tb/clamp_lut_tb.sv
`timescale 1ns/1ps
module clamp_lut_tb;

  localparam int OUT_W = 27;

  typedef struct {
    longint          value;
    logic [OUT_W-1:0] expect_d;
    string            tag;
  } item_t;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             valid_i = 1'b0;
  logic [63:0]      value_i = '0;
  logic             valid_o;
  logic [OUT_W-1:0] data_o;

  int    n_checks = 0;
  int    n_errors = 0;
  bit    finished = 1'b0;
  item_t sb_q[$];
  logic [OUT_W-1:0] last_exp = '0;

  always #5 clk_i = ~clk_i;

  clamp_lut u_dut (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(valid_i),
    .value_i(value_i),
    .valid_o(valid_o),
    .data_o (data_o)
  );

  function automatic logic [OUT_W-1:0] model(input longint x);
    if (x >= 100)  return OUT_W'(99504950);
    if (x <= -100) return OUT_W'(495050);
    return OUT_W'((x + 100) * 500000);
  endfunction

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic send(input longint x, input string tag);
    item_t it;
    @(negedge clk_i);
    valid_i = 1'b1;
    value_i = x;
    it.value    = x;
    it.expect_d = model(x);
    it.tag      = tag;
    sb_q.push_back(it);
    last_exp = it.expect_d;
  endtask

  task automatic go_idle();
    @(negedge clk_i);
    valid_i = 1'b0;
  endtask

  // Monitor: one result due one edge after acceptance.
  always @(negedge clk_i) begin
    if (rst_ni && valid_o && !finished) begin
      if (sb_q.size() == 0) begin
        check(1'b0, "R2 spurious valid_o", 1, 0);
      end else begin
        item_t it;
        it = sb_q.pop_front();
        check(data_o == it.expect_d, it.tag, longint'(data_o), longint'(it.expect_d));
      end
    end
  end

  task automatic finish_run();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  endtask

  initial begin
    #2_000_000;
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_run();
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk_i);
    check(valid_o == 1'b0, "R1 valid_o in reset", longint'(valid_o), 0);
    check(data_o == '0, "R1 data_o in reset", longint'(data_o), 0);
    rst_ni = 1'b1;

    // R3 named points and a full sweep, streamed back to back (R2 ordering)
    send(-100, "R3 x=-100");
    send(-99,  "R3 x=-99");
    send(99,   "R3 x=99");
    send(100,  "R3 x=100");
    send(0,    "R3 x=0");
    for (int x = -100; x <= 100; x++) send(longint'(x), "R3 sweep");
    go_idle();
    repeat (2) @(negedge clk_i);
    check(sb_q.size() == 0, "R2 results drained", sb_q.size(), 0);

    // R4/R5 just past the window
    send(101,  "R4 x=101");
    send(-101, "R5 x=-101");
    // R7 narrow band corners
    send(127,  "R7 x=127");
    send(128,  "R7 x=128");
    send(255,  "R7 x=255");
    send(-128, "R7 x=-128");
    send(-129, "R7 x=-129");
    send(-256, "R7 x=-256");
    send(-1,   "R7 x=-1 inside");
    // R6 upper-bit decisions
    send(256,  "R6 x=256");
    send(-257, "R6 x=-257");
    send(longint'(64'h4000_0000_0000_0000), "R6 bit62 only");
    send(longint'(64'h7FFF_FFFF_FFFF_FFFF), "R6 max positive");
    send(longint'(64'h8000_0000_0000_0000), "R6 min negative");
    send(longint'(64'hFFFF_FFFF_FFFF_FE9C), "R6 -356");
    send(longint'(64'h0000_0100_0000_0064), "R6 hidden high bit +100 low");
    send(longint'(64'hFFFF_FEFF_FFFF_FF9C), "R6 hidden low bit -100 low");
    go_idle();

    // R8: idle cycles with a disturbing value_i
    value_i = 64'd5;
    repeat (3) begin
      @(negedge clk_i);
      check(valid_o == 1'b0, "R8 valid_o idle", longint'(valid_o), 0);
      check(data_o == last_exp, "R8 data_o held", longint'(data_o), longint'(last_exp));
    end
    value_i = 64'hFFFF_FFFF_FFFF_FFFF;
    @(negedge clk_i);
    check(data_o == last_exp, "R8 data_o held (x=-1 idle)", longint'(data_o), longint'(last_exp));

    // R2 single isolated transfer
    send(42, "R2 single x=42");
    go_idle();
    @(negedge clk_i);
    check(valid_o == 1'b0, "R2 valid_o drops", longint'(valid_o), 0);
    check(sb_q.size() == 0, "R2 all results seen", sb_q.size(), 0);

    finish_run();
  end

endmodule